// File: doc/BRIEF.md
# Chained Per-Layer LFSR Test Decompressor

This block expands compressed tester stimulus into scan-chain data for a three-die stack. Every die has its own 64-stage linear feedback shift register. Each shift cycle, the register takes a group of input channels and XORs each channel into a fixed stage. A small XOR network reads the register and drives that die's scan chains. The lowest die takes its channels straight from the tester. Each higher die takes its channels from a few stages of the register in the die just below it. Free variables that a lower die does not need can therefore be used further up the stack. Only this narrowing set of compressed bits crosses between dies: 8 channels into the bottom, 4 from bottom to middle, and 2 from middle to top.

All three registers step together when shifting is enabled, so one test cube per die is expanded at the same time as a group. A synchronous cube clear returns every register to zero between cubes. The tester data for a group is solved off-chip against exactly this linear behaviour, so the stage numbering, the feedback taps and the channel positions given below are part of the contract.

Top module: `chained_test_decomp`

## Requirements
- R1: While `rst_n` is low, all three registers are held at zero, so every scan output reads 0. A register that is zero and receives all-zero channel bits stays zero.
- R2: When `cube_reset` is high at a rising clock edge, all three registers become zero, whatever `shift_en` and `tester_in` are.
- R3: When `shift_en` is low and `cube_reset` is low, all three registers keep their value, and the scan outputs do not change, whatever `tester_in` is.
- R4: On a shift, each register moves up one place (stage i+1 takes stage i), and stage 0 takes the XOR of stages 63, 62, 60 and 59. This is the primitive polynomial x^64+x^63+x^61+x^60+1. Channel injection is XORed on top of this.
- R5: In the bottom register, tester channel k (k = 0..7, bit k of `tester_in`) is XORed into stage 8k during a shift.
- R6: Middle-register channel j (j = 0..3) is bottom stage 16j+15 and is XORed into middle stage 16j. Top-register channel j (j = 0..1) is middle stage 32j+31 and is XORed into top stage 32j. Every value is taken from the register contents before the edge.
- R7: Scan chain c (c = 0..3) of each die is the combinational XOR of that die's stages 16c+5, (16c+22) mod 64 and (16c+39) mod 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock shared by the three dies |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Advances all three registers when high |
| cube_reset | input | 1 | Synchronous clear of all registers, has priority over shifting |
| tester_in | input | 8 | Compressed channel bits from the tester into the bottom die |
| scan_l0 | output | 4 | Scan-chain inputs of the bottom die |
| scan_l1 | output | 4 | Scan-chain inputs of the middle die |
| scan_l2 | output | 4 | Scan-chain inputs of the top die |

## Verification
The scan outputs are combinational from the registers. A stimulus applied before an edge therefore shows up on all twelve scan bits right after that one edge. A channel bit needs further shifts to climb into a higher die: one edge to enter the bottom register, then enough shifts to reach an export stage, then one more edge to enter the next register. The bench drives inputs at the falling edge and advances its own model of the three registers for the coming rising edge. It compares every scan bit one time unit after that rising edge, so each comparison covers exactly one step. Single-channel directed cases are followed for many cycles so that each bit is seen in every die.

// File: rtl/chained_test_decomp_pkg.sv
package chained_test_decomp_pkg;

  localparam int STAGES = 64;

  // one Fibonacci step: shift upward, parity of masked stages enters stage 0
  function automatic logic [STAGES-1:0] lfsr_advance(input logic [STAGES-1:0] s,
                                                     input logic [STAGES-1:0] poly);
    return {s[STAGES-2:0], ^(s & poly)};
  endfunction

  // stage that receives channel k when a register has chw channels
  function automatic int inj_stage(input int k, input int chw);
    return k * (STAGES / chw);
  endfunction

  // stage exported as upper-die channel j when chw channels go upward
  function automatic int tap_stage(input int j, input int chw);
    return j * (STAGES / chw) + (STAGES / chw) - 1;
  endfunction

  // stage read by term t of scan chain c
  function automatic int mix_stage(input int c, input int t, input int nch,
                                   input int gap, input int off);
    return (c * (STAGES / nch) + t * gap + off) % STAGES;
  endfunction

endpackage

// File: rtl/layer_lfsr.sv
module layer_lfsr
  import chained_test_decomp_pkg::*;
#(
  parameter logic [STAGES-1:0] POLY = 64'hD800_0000_0000_0000,
  parameter int CH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              cube_reset,
  input  logic [CH_W-1:0]   chan_in,
  output logic [STAGES-1:0] state_q
);

  logic [STAGES-1:0] inject_vec;
  logic [STAGES-1:0] state_nxt;

  always_comb begin
    inject_vec = '0;
    for (int k = 0; k < CH_W; k++) begin
      inject_vec[inj_stage(k, CH_W)] = chan_in[k];
    end
  end

  assign state_nxt = lfsr_advance(state_q, POLY) ^ inject_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (cube_reset) begin
      state_q <= '0;
    end else if (shift_en) begin
      state_q <= state_nxt;
    end
  end

endmodule

// File: rtl/xor_phase_shifter.sv
module xor_phase_shifter
  import chained_test_decomp_pkg::*;
#(
  parameter int N_CHAINS = 4,
  parameter int N_TERMS  = 3,
  parameter int GAP      = 17,
  parameter int OFFSET   = 5
) (
  input  logic [STAGES-1:0]   state_in,
  output logic [N_CHAINS-1:0] chain_out
);

  always_comb begin
    for (int c = 0; c < N_CHAINS; c++) begin
      logic acc;
      acc = 1'b0;
      for (int t = 0; t < N_TERMS; t++) begin
        acc = acc ^ state_in[mix_stage(c, t, N_CHAINS, GAP, OFFSET)];
      end
      chain_out[c] = acc;
    end
  end

endmodule

// File: rtl/chained_test_decomp.sv
module chained_test_decomp
  import chained_test_decomp_pkg::*;
#(
  parameter logic [STAGES-1:0] POLY = 64'hD800_0000_0000_0000,
  parameter int CH0_W    = 8,
  parameter int CH1_W    = 4,
  parameter int CH2_W    = 2,
  parameter int N_CHAINS = 4,
  parameter int N_TERMS  = 3,
  parameter int MIX_GAP  = 17,
  parameter int MIX_OFF  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                cube_reset,
  input  logic [CH0_W-1:0]    tester_in,
  output logic [N_CHAINS-1:0] scan_l0,
  output logic [N_CHAINS-1:0] scan_l1,
  output logic [N_CHAINS-1:0] scan_l2
);

  localparam int N_LAYERS = 3;

  function automatic int layer_ch(input int l);
    return (l == 0) ? CH0_W : ((l == 1) ? CH1_W : CH2_W);
  endfunction

  if (!(CH0_W > CH1_W && CH1_W > CH2_W && CH2_W > 0)) begin : g_taper_bad
    $error("channel widths must narrow going up the stack");
  end

  logic [STAGES-1:0]   layer_state [N_LAYERS];
  logic [N_CHAINS-1:0] layer_scan  [N_LAYERS];

  for (genvar l = 0; l < N_LAYERS; l++) begin : g_layer
    localparam int CW = layer_ch(l);
    logic [CW-1:0] chan;

    if (l == 0) begin : g_from_tester
      assign chan = tester_in;
    end else begin : g_from_below
      for (genvar j = 0; j < CW; j++) begin : g_tap
        assign chan[j] = layer_state[l-1][tap_stage(j, CW)];
      end
    end

    layer_lfsr #(
      .POLY (POLY),
      .CH_W (CW)
    ) lfsr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_en   (shift_en),
      .cube_reset (cube_reset),
      .chan_in    (chan),
      .state_q    (layer_state[l])
    );

    xor_phase_shifter #(
      .N_CHAINS (N_CHAINS),
      .N_TERMS  (N_TERMS),
      .GAP      (MIX_GAP),
      .OFFSET   (MIX_OFF)
    ) mix_i (
      .state_in  (layer_state[l]),
      .chain_out (layer_scan[l])
    );
  end

  // named copies for the checker
  logic [STAGES-1:0] st_bot, st_mid, st_top;
  assign st_bot = layer_state[0];
  assign st_mid = layer_state[1];
  assign st_top = layer_state[2];

  assign scan_l0 = layer_scan[0];
  assign scan_l1 = layer_scan[1];
  assign scan_l2 = layer_scan[2];

endmodule

// File: rtl/chained_test_decomp_chk.sv
module chained_test_decomp_chk
  import chained_test_decomp_pkg::*;
#(
  parameter logic [STAGES-1:0] POLY = 64'hD800_0000_0000_0000,
  parameter int CH0_W    = 8,
  parameter int N_CHAINS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                shift_en,
  input logic                cube_reset,
  input logic [CH0_W-1:0]    tester_in,
  input logic [STAGES-1:0]   st_bot,
  input logic [STAGES-1:0]   st_mid,
  input logic [STAGES-1:0]   st_top,
  input logic [N_CHAINS-1:0] scan_l0,
  input logic [N_CHAINS-1:0] scan_l1,
  input logic [N_CHAINS-1:0] scan_l2
);

  // R1
  zero_stays_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_bot == '0 && tester_in == '0) |=> (st_bot == '0));

  // R2
  cube_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cube_reset |=> (st_bot == '0 && st_mid == '0 && st_top == '0));

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !cube_reset) |=> ($stable(st_bot) && $stable(st_mid) && $stable(st_top)));

  // R4
  shift_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cube_reset) |=> (st_bot[7:1] == $past(st_bot[6:0])));

  // R5
  tester_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cube_reset) |=> (st_bot[8] == ($past(st_bot[7]) ^ $past(tester_in[1]))));

  // R6
  upward_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cube_reset) |=>
      (st_mid[0] == ($past(^(st_mid & POLY)) ^ $past(st_bot[15]))));

  // R7
  quiet_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_bot == '0 && st_mid == '0 && st_top == '0) |->
      (scan_l0 == '0 && scan_l1 == '0 && scan_l2 == '0));

endmodule

bind chained_test_decomp chained_test_decomp_chk #(
  .POLY     (POLY),
  .CH0_W    (CH0_W),
  .N_CHAINS (N_CHAINS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .shift_en   (shift_en),
  .cube_reset (cube_reset),
  .tester_in  (tester_in),
  .st_bot     (st_bot),
  .st_mid     (st_mid),
  .st_top     (st_top),
  .scan_l0    (scan_l0),
  .scan_l1    (scan_l1),
  .scan_l2    (scan_l2)
);

// File: tb/chained_test_decomp_tb_top.sv
module chained_test_decomp_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shift_en = 1'b0;
  logic       cube_reset = 1'b0;
  logic [7:0] tester_in = 8'h00;
  logic [3:0] scan_l0, scan_l1, scan_l2;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic [63:0] mdl_bot = '0, mdl_mid = '0, mdl_top = '0;

  always #2 clk = ~clk;

  chained_test_decomp dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .cube_reset (cube_reset),
    .tester_in  (tester_in),
    .scan_l0    (scan_l0),
    .scan_l1    (scan_l1),
    .scan_l2    (scan_l2)
  );

  // entries: {shift_en, cube_reset, tester bits}
  localparam logic [9:0] VEC [16] = '{
    10'b10_1010_0101, 10'b10_0000_0001, 10'b10_1000_0000, 10'b00_1111_1111,
    10'b10_0110_1001, 10'b10_1111_0000, 10'b10_0000_1111, 10'b00_0011_1100,
    10'b10_1100_0011, 10'b10_0101_1010, 10'b10_0001_0000, 10'b10_1001_1001,
    10'b11_1111_1111, 10'b10_0111_1110, 10'b10_0010_0100, 10'b10_1110_0111
  };

  function automatic logic [63:0] mdl_shift(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  function automatic logic [3:0] mdl_scan(input logic [63:0] s);
    logic [3:0] r;
    for (int c = 0; c < 4; c++) begin
      r[c] = s[(16*c + 5) % 64] ^ s[(16*c + 22) % 64] ^ s[(16*c + 39) % 64];
    end
    return r;
  endfunction

  task automatic mdl_tick(input logic se, input logic cr, input logic [7:0] tin);
    logic [63:0] nb, nm, nt;
    if (cr) begin
      nb = '0; nm = '0; nt = '0;
    end else if (se) begin
      nb = mdl_shift(mdl_bot);
      nm = mdl_shift(mdl_mid);
      nt = mdl_shift(mdl_top);
      for (int k = 0; k < 8; k++) nb[8*k] = nb[8*k] ^ tin[k];
      for (int j = 0; j < 4; j++) nm[16*j] = nm[16*j] ^ mdl_bot[16*j + 15];
      for (int j = 0; j < 2; j++) nt[32*j] = nt[32*j] ^ mdl_mid[32*j + 31];
    end else begin
      nb = mdl_bot; nm = mdl_mid; nt = mdl_top;
    end
    mdl_bot = nb; mdl_mid = nm; mdl_top = nt;
  endtask

  task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    check4({tag, " bottom"}, scan_l0, mdl_scan(mdl_bot));
    check4({tag, " middle"}, scan_l1, mdl_scan(mdl_mid));
    check4({tag, " top"},    scan_l2, mdl_scan(mdl_top));
  endtask

  task automatic step(input logic se, input logic cr, input logic [7:0] tin, input string tag);
    @(negedge clk);
    shift_en = se; cube_reset = cr; tester_in = tin;
    mdl_tick(se, cr, tin);
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  initial begin
    logic [3:0] hold0, hold1, hold2;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs idle under reset
    check_all("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 8'h00, "R1 zero stays zero");

    // table walk: R4 R5 R6 R7 under varied patterns
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 16; i++) begin
        step(VEC[i][9], VEC[i][8], VEC[i][7:0] ^ 8'(p * 8'h5B), "R4 R5 R6 R7 table");
      end
    end

    // R2: clear wins over shift with live channels
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 8'hC3, "R4 fill");
    step(1'b1, 1'b1, 8'hFF, "R2 clear beats shift");
    check4("R2 bottom zero", scan_l0, 4'h0);
    check4("R2 top zero", scan_l2, 4'h0);

    // R3: hold with nonzero channels
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 8'(i * 37 + 1), "R6 fill");
    hold0 = scan_l0; hold1 = scan_l1; hold2 = scan_l2;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 8'hA5, "R3 hold");
    check4("R3 bottom unchanged", scan_l0, hold0);
    check4("R3 middle unchanged", scan_l1, hold1);
    check4("R3 top unchanged", scan_l2, hold2);

    // R5 R6: single channel bits followed upward through the stack
    step(1'b0, 1'b1, 8'h00, "R2 clear");
    step(1'b1, 1'b0, 8'h01, "R5 lowest channel");
    for (int i = 0; i < 70; i++) step(1'b1, 1'b0, 8'h00, "R6 lowest channel climbs");
    step(1'b0, 1'b1, 8'h00, "R2 clear");
    step(1'b1, 1'b0, 8'h80, "R5 highest channel");
    for (int i = 0; i < 70; i++) step(1'b1, 1'b0, 8'h00, "R6 highest channel climbs");

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    mdl_bot = '0; mdl_mid = '0; mdl_top = '0;
    #1;
    check_all("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 8'h00, "R1 after reset");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule